// File: doc/BRIEF.md
# Command-Parser Microcontroller ALU

This block is the arithmetic and logic unit of a small microcontroller that walks a command stream and programs hardware registers. Each cycle it takes an opcode, a first source value and a second operand, and it returns a 32-bit result and a carry-out. The second operand is either a second register value or a 16-bit immediate that is zero-extended. The result path is purely combinational.

The only state the block holds is a single carry bit. It loads only when an issued instruction is a plain add or a plain subtract. A following add-high or subtract-high consumes it, so two instructions in a row can build 64-bit sums and differences. The compare operation does not return a boolean. It returns one of three fixed codes whose bit patterns let a later single-bit branch test express less-than, less-or-equal, greater-than and similar conditions.

Top module: `ucu_alu`

## Requirements
- R1: When `use_imm` is 1 the second operand B is `imm` zero-extended to 32 bits and `src_b` is ignored; when `use_imm` is 0, B is `src_b`.
- R2: Opcode 0 (add) gives A+B with `carry_out` equal to the unsigned carry out of bit 31. Opcode 2 (sub) gives A-B with `carry_out` equal to 1 exactly when A < B unsigned (borrow).
- R3: Opcode 1 (add-high) gives A+B+`carry_q`. Opcode 3 (sub-high) gives A-B-`carry_q`. `carry_out` is the carry or borrow of that full operation.
- R4: `carry_q` is 0 after a clock with `rst_n` low. It takes `carry_out` at a clock where `issue` is 1 and the opcode is 0 or 2. It holds its value at every other clock.
- R5: Opcodes 4, 5 and 6 give A AND B, A OR B and A XOR B. Opcode 7 (not) gives ~B, and A has no effect on it.
- R6: Opcodes 8 (shift left), 9 (logical right) and 10 (arithmetic right, sign-filling from A[31]) shift A by B[4:0]; bits B[31:5] are ignored.
- R7: Opcode 11 rotates A left by B[4:0]; bits leaving bit 31 re-enter at bit 0.
- R8: Opcode 12 gives A[7:0]*B[7:0] as an unsigned 16-bit product, with bits 31:16 zero.
- R9: Opcodes 13 (min) and 14 (max) return the unsigned smaller or larger of A and B.
- R10: Opcode 15 (compare) returns 0x00 when A > B, 0x2b when A == B and 0x1e when A < B, all unsigned.
- R11: `carry_out` is 0 for every opcode other than 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the carry register |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | An instruction is executed this cycle |
| op | input | 4 | Opcode, encoded as in R2 to R10 |
| src_a | input | 32 | First source value A |
| src_b | input | 32 | Second source register value |
| imm | input | 16 | Immediate field |
| use_imm | input | 1 | Selects the immediate as B |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Carry or borrow of the current operation |
| carry_q | output | 1 | Stored carry used by add-high and sub-high |

## Verification
The bench chains an add that overflows into an add-high, and a subtract that borrows into a sub-high. A carry register that loads on the wrong opcodes, or that loads without `issue`, would corrupt the upper word. It shifts and rotates by 0, by 31 and by amounts above 31, which catches a design that uses more than five bits or rotates by zero wrongly. It also drives negative values into the arithmetic shift and, with the top bit set, into min and max, where signed logic would give a different answer. It hits all three compare outcomes and uses an immediate with bit 15 set, which exposes sign extension.

// File: rtl/ucu_alu_pkg.sv
// Package: opcode encoding and compare result codes shared by the ALU units.
// Assumes a 4-bit opcode field; the compare codes are fixed by branch usage.
package ucu_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDHI = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBHI = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_XOR   = 4'd6,
        OP_NOT   = 4'd7,
        OP_SHL   = 4'd8,
        OP_USHR  = 4'd9,
        OP_ISHR  = 4'd10,
        OP_ROT   = 4'd11,
        OP_MUL8  = 4'd12,
        OP_MIN   = 4'd13,
        OP_MAX   = 4'd14,
        OP_CMP   = 4'd15
    } alu_op_e;

    localparam logic [7:0] CMP_GT = 8'h00;
    localparam logic [7:0] CMP_EQ = 8'h2b;
    localparam logic [7:0] CMP_LT = 8'h1e;

endpackage

// File: rtl/ucu_alu_arith.sv
// Arithmetic unit: add/sub with and without stored carry, min, max, compare.
// Assumes unsigned operands; cout is driven only for the four add/sub opcodes.
module ucu_alu_arith
    import ucu_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);
    localparam int unsigned CODE_W = 8;

    logic [W:0] sum;
    logic [W:0] dif;
    logic       add_ci;
    logic       sub_bi;

    // Full-width sum and difference, with stored carry only for the high forms
    always_comb begin
        add_ci = (op == OP_ADDHI) && cin;
        sub_bi = (op == OP_SUBHI) && cin;
        sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, add_ci};
        dif = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, sub_bi};
    end

    // Select the result and carry for the requested arithmetic opcode
    always_comb begin
        res  = '0;
        cout = 1'b0;
        unique case (op)
            OP_ADD, OP_ADDHI: begin
                res  = sum[W-1:0];
                cout = sum[W];
            end
            OP_SUB, OP_SUBHI: begin
                res  = dif[W-1:0];
                cout = dif[W];
            end
            OP_MIN: res = (a < b) ? a : b;
            OP_MAX: res = (a > b) ? a : b;
            OP_CMP: begin
                if (a > b)       res = {{(W-CODE_W){1'b0}}, CMP_GT};
                else if (a == b) res = {{(W-CODE_W){1'b0}}, CMP_EQ};
                else             res = {{(W-CODE_W){1'b0}}, CMP_LT};
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/ucu_alu_logic.sv
// Logic unit: bitwise ops, shifts, rotate and the narrow multiply.
// Assumes shift amounts come from the low log2(W) bits of b.
module ucu_alu_logic
    import ucu_alu_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned MUL_W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);
    localparam int unsigned SH_W   = $clog2(W);
    localparam int unsigned PROD_W = 2 * MUL_W;

    logic [SH_W-1:0]   sh;
    logic [2*W-1:0]    rot_wide;
    logic [PROD_W-1:0] prod;

    // Shift amount, rotate by double-width shift, narrow product
    always_comb begin
        sh       = b[SH_W-1:0];
        rot_wide = {a, a} << sh;
        prod     = a[MUL_W-1:0] * b[MUL_W-1:0];
    end

    // Select the result for the requested logic opcode
    always_comb begin
        res = '0;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~b;
            OP_SHL:  res = a << sh;
            OP_USHR: res = a >> sh;
            OP_ISHR: res = W'($signed(a) >>> sh);
            OP_ROT:  res = rot_wide[2*W-1:W];
            OP_MUL8: res = {{(W-PROD_W){1'b0}}, prod};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/ucu_alu_carry.sv
// Carry register: keeps the carry of the last issued add or sub.
// Assumes the caller decides when to load; synchronous active-low reset.
module ucu_alu_carry (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic d,
    output logic q
);
    // Store the carry on load, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (load) q <= d;
    end

    // R4
    carry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R4
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/ucu_alu.sv
// Top: operand select, arithmetic and logic units, result mux, carry register.
// Assumes one instruction per cycle when issue is high; result is combinational.
module ucu_alu
    import ucu_alu_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [3:0]       op,
    input  logic [W-1:0]     src_a,
    input  logic [W-1:0]     src_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    output logic [W-1:0]     result,
    output logic             carry_out,
    output logic             carry_q
);
    localparam int unsigned MUL_W  = 8;
    localparam int unsigned PROD_W = 2 * MUL_W;

    alu_op_e        op_e;
    logic [W-1:0]   opnd_b;
    logic [W-1:0]   ares;
    logic [W-1:0]   lres;
    logic           acout;
    logic           is_logic;
    logic           load_c;

    // Decode opcode, pick second operand, classify the unit
    always_comb begin
        op_e     = alu_op_e'(op);
        opnd_b   = use_imm ? {{(W-IMM_W){1'b0}}, imm} : src_b;
        is_logic = (op_e inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SHL,
                                 OP_USHR, OP_ISHR, OP_ROT, OP_MUL8});
        load_c   = issue && (op_e == OP_ADD || op_e == OP_SUB);
    end

    ucu_alu_arith #(.W(W)) u_arith (
        .op   (op_e),
        .a    (src_a),
        .b    (opnd_b),
        .cin  (carry_q),
        .res  (ares),
        .cout (acout)
    );

    ucu_alu_logic #(.W(W), .MUL_W(MUL_W)) u_logic (
        .op  (op_e),
        .a   (src_a),
        .b   (opnd_b),
        .res (lres)
    );

    ucu_alu_carry u_carry (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_c),
        .d     (acout),
        .q     (carry_q)
    );

    // Merge unit outputs
    always_comb begin
        result    = is_logic ? lres : ares;
        carry_out = acout;
    end

    // R10
    cmp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd15) |-> (result == 32'h0 || result == 32'h2b || result == 32'h1e));

    // R8
    mul8_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd12) |-> (result[W-1:PROD_W] == '0));

    // R9
    min_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd13) |-> (result <= src_a && (result == src_a || result == opnd_b)));

    // R11
    carry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op > 4'd3) |-> !carry_out);

    // R1
    imm_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_imm && op == 4'd4) |-> (result[W-1:IMM_W] == '0));
endmodule

// File: tb/tb_ucu_alu.sv
module tb_ucu_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm = '0;
    logic        use_imm = 1'b0;
    logic [31:0] result;
    logic        carry_out;
    logic        carry_q;

    int checks = 0;
    int fails  = 0;
    bit mdl_c  = 1'b0;

    always #10 clk = ~clk;

    ucu_alu dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op),
        .src_a(src_a), .src_b(src_b), .imm(imm), .use_imm(use_imm),
        .result(result), .carry_out(carry_out), .carry_q(carry_q)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: returns {carry, result}
    function automatic logic [32:0] ref_op(int o, longint unsigned a,
                                           longint unsigned b, bit c);
        longint unsigned r;
        longint signed   s;
        int sh = int'(b % 32);
        case (o)
            0: r = a + b;
            1: r = a + b + c;
            2: return {(a < b), 32'((a - b) & 64'hffffffff)};
            3: return {(a < b + c), 32'((a - b - c) & 64'hffffffff)};
            4: r = a & b;
            5: r = a | b;
            6: r = a ^ b;
            7: r = (~b) & 64'hffffffff;
            8: r = (a << sh) & 64'hffffffff;
            9: r = a >> sh;
            10: begin
                s = (a >= 64'h80000000) ? longint'(a) - 64'sh100000000 : longint'(a);
                r = longint'(s >>> sh) & 64'hffffffff;
            end
            11: r = ((a << sh) | (a >> (32 - sh))) & 64'hffffffff;
            12: r = (a % 256) * (b % 256);
            13: r = (a < b) ? a : b;
            14: r = (a > b) ? a : b;
            default: r = (a > b) ? 64'h00 : ((a == b) ? 64'h2b : 64'h1e);
        endcase
        return {(o <= 1) ? r[32] : 1'b0, r[31:0]};
    endfunction

    function automatic string tag_of(int o);
        case (o)
            0, 2: return "R2";
            1, 3: return "R3";
            4, 5, 6, 7: return "R5";
            8, 9, 10: return "R6";
            11: return "R7";
            12: return "R8";
            13, 14: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic step(bit iss, int o, logic [31:0] a, logic [31:0] b,
                        logic [15:0] im, bit ui, string tag);
        logic [32:0] e;
        logic [31:0] bv;
        @(negedge clk);
        issue = iss; op = 4'(o); src_a = a; src_b = b; imm = im; use_imm = ui;
        bv = ui ? {16'h0, im} : b;
        e = ref_op(o, {32'h0, a}, {32'h0, bv}, mdl_c);
        #2;
        chk(tag, result, e[31:0]);
        chk((o > 3) ? "R11" : tag, {31'h0, carry_out}, {31'h0, e[32]});
        if (iss && (o == 0 || o == 2)) mdl_c = e[32];
        @(posedge clk);
        #2;
        chk("R4", {31'h0, carry_q}, {31'h0, mdl_c});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R4", {31'h0, carry_q}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 / R3: 64-bit add chain
        step(1, 0, 32'hffffffff, 32'h1, 16'h0, 0, "R2");
        step(1, 1, 32'h0, 32'h0, 16'h0, 0, "R3");
        // R2 / R3: 64-bit sub chain
        step(1, 2, 32'h0, 32'h1, 16'h0, 0, "R2");
        step(1, 3, 32'h5, 32'h0, 16'h0, 0, "R3");
        step(1, 3, 32'h0, 32'h0, 16'h0, 0, "R3");
        // R4: add without issue leaves carry
        step(1, 2, 32'h0, 32'h1, 16'h0, 0, "R4");
        step(0, 0, 32'h1, 32'h1, 16'h0, 0, "R4");
        step(1, 1, 32'h1, 32'h1, 16'h0, 0, "R4");
        // R1: immediate with bit 15 set, src_b ignored
        step(1, 4, 32'hffffffff, 32'h12345678, 16'h8001, 1, "R1");
        step(1, 0, 32'h1, 32'hdeadbeef, 16'hffff, 1, "R1");
        // R5: not ignores A, from register and immediate
        step(1, 7, 32'hffffffff, 32'h0f0f0f0f, 16'h0, 0, "R5");
        step(1, 7, 32'h12345678, 32'h0, 16'h00ff, 1, "R5");
        // R6: shift amounts 0, 31, 33
        step(1, 8, 32'h80000001, 32'd33, 16'h0, 0, "R6");
        step(1, 10, 32'h80000000, 32'd31, 16'h0, 0, "R6");
        step(1, 9, 32'h80000000, 32'd31, 16'h0, 0, "R6");
        step(1, 10, 32'h40000000, 32'd0, 16'h0, 0, "R6");
        // R7: rotate by 0, 4, 31
        step(1, 11, 32'h80000001, 32'd0, 16'h0, 0, "R7");
        step(1, 11, 32'hf000000f, 32'd4, 16'h0, 0, "R7");
        step(1, 11, 32'h00000003, 32'd31, 16'h0, 0, "R7");
        // R8: high bits of operands ignored
        step(1, 12, 32'h000001ff, 32'hffffffff, 16'h0, 0, "R8");
        // R9: unsigned ordering with top bit set
        step(1, 13, 32'h80000000, 32'h1, 16'h0, 0, "R9");
        step(1, 14, 32'h80000000, 32'h1, 16'h0, 0, "R9");
        // R10: all three compare codes
        step(1, 15, 32'h9, 32'h3, 16'h0, 0, "R10");
        step(1, 15, 32'h7, 32'h7, 16'h0, 0, "R10");
        step(1, 15, 32'h1, 32'h80000000, 16'h0, 0, "R10");
        // Mixed stimulus over all opcodes
        for (int i = 0; i < 3000; i++) begin
            int o = int'($urandom % 16);
            step(($urandom % 4) != 0, o, $urandom, $urandom, 16'($urandom),
                 ($urandom % 2) == 1, tag_of(o));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule